// File: doc/BRIEF.md
# Pin interrupt GPIO controller

A 32-pin general-purpose I/O block on a plain 32-bit register bus. Software picks each pin's direction, writes the levels that output pins drive, and reads back either those written levels or the live levels of input pins. Asynchronous pin inputs pass through a two-flop synchronizer. The synchronized value is the sampled pin state, and one more register holds the previous sample for edge comparison.

Each input pin can flag an interrupt on a low level, a high level, a rising edge or a falling edge. A per-pin override instead flags any change of level. Flags collect in a status register that software clears by writing ones. A mask register gates the flags onto either one combined interrupt line or two lines, one for each 16-pin half. Two build parameters select the split interrupt outputs and remove the both-edge override.

The bus has no handshake. A write takes effect at the clock edge where `bus_wr` is high. Read data is a combinational function of `bus_addr` and the current register state. Only word-aligned offsets are decoded.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: While `rst_n` is low, every register reads 0, `pin_oe` and `pin_out` are 0 and `irq` is 0, so all pins are inputs and all interrupts are masked.
- R2: Writing the direction register (offset 0x04) sets `pin_oe` to the written value at the next clock edge. A 1 bit marks an output. `pin_out` carries the data register (offset 0x00) bit where the direction bit is 1 and 0 elsewhere.
- R3: A read of offset 0x00 returns, for each pin, the data register bit if the direction bit is 1 and the sampled pin bit if it is 0.
- R4: A read of offset 0x08 returns the sampled pin state with the bits of output pins forced to 0. A change on `pin_in` shows there after the second rising clock edge.
- R5: Pin n uses the 2-bit mode at bits 2n+1:2n of the 64-bit value {offset 0x10, offset 0x0C}, so offset 0x0C holds pins 0 to 15. Mode 00 flags the pin in the status register (offset 0x18) while its sample is 0. Mode 01 flags it while its sample is 1.
- R6: Mode 10 flags a 0-to-1 change of the sample and mode 11 flags a 1-to-0 change. The flag appears after the third rising edge following the pin change.
- R7: When bit n of the both-edge register (offset 0x1C) is 1, pin n's mode is ignored and any change of its sample sets flag n.
- R8: Writing offset 0x18 clears each flag written as 1 and leaves flags written as 0 unchanged. A level-mode flag whose level is still present stays set.
- R9: Pins with direction bit 1 never set flags. Writes to direction or mode registers alone never produce an edge.
- R10: With split mode off, `irq[0]` is the OR of flags AND mask (offset 0x14) and `irq[1]` is 0. With split mode on, `irq[0]` covers bits 15:0 and `irq[1]` covers bits 31:16.
- R11: With the both-edge override removed, offset 0x1C reads 0, writes to it are ignored and every pin follows its mode.
- R12: Offsets above 0x1C and offsets that are not word-aligned read 0, and writes to them change nothing.
- R13: The direction, both mode registers, the mask and the both-edge register read back the last value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled at the rising edge |
| bus_addr | input | 6 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| pin_in | input | 32 | Asynchronous pin levels |
| pin_out | output | 32 | Output pin levels |
| pin_oe | output | 32 | Output enable per pin |
| irq | output | 2 | Interrupt lines, combined or split by half |

## Verification
Register writes are visible on a read and on `pin_oe` one edge after the strobe. The sampled pin state moves two edges after a pin change, and a flag or interrupt follows one edge after that. The bench drives every input on the falling edge and reads shortly after it. It waits exactly those counts: two edges before it expects a new sample and three before it expects a flag. One check also confirms that the flag is still clear after only two edges. A second instance built with split outputs and no both-edge override shares all the inputs, so each scenario compares the two builds.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
    localparam int NPINS  = 32;
    localparam int HALF   = NPINS / 2;
    localparam int CFG_W  = 2 * NPINS;
    localparam int ADDR_W = 6;
    localparam int NREGS  = 8;

    typedef enum logic [2:0] {
        REG_DATA   = 3'd0,
        REG_DIR    = 3'd1,
        REG_STAT   = 3'd2,
        REG_CFG_LO = 3'd3,
        REG_CFG_HI = 3'd4,
        REG_MASK   = 3'd5,
        REG_FLAG   = 3'd6,
        REG_BOTH   = 3'd7
    } reg_sel_e;

    typedef enum logic [1:0] {
        TRIG_LOW  = 2'b00,
        TRIG_HIGH = 2'b01,
        TRIG_RISE = 2'b10,
        TRIG_FALL = 2'b11
    } trig_mode_e;
endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    logic [W-1:0] stage1;
    logic [W-1:0] stage2;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= '0;
            stage2 <= '0;
        end else begin
            stage1 <= d_async;
            stage2 <= stage1;
        end
    end

    assign q_sync = stage2;
endmodule

// File: rtl/gpio_trig_detect.sv
module gpio_trig_detect
    import gpio_irq_pkg::*;
#(
    parameter int N = NPINS
) (
    input  logic [N-1:0]   smp,
    input  logic [N-1:0]   prev,
    input  logic [N-1:0]   dir,
    input  logic [2*N-1:0] cfg,
    input  logic [N-1:0]   both,
    output logic [N-1:0]   set_vec
);
    for (genvar p = 0; p < N; p++) begin : g_pin
        trig_mode_e mode;
        logic       mode_hit;
        logic       any_edge;

        assign mode     = trig_mode_e'(cfg[2*p +: 2]);
        assign any_edge = smp[p] ^ prev[p];

        always_comb begin
            mode_hit = 1'b0;
            unique case (mode)
                TRIG_LOW:  mode_hit = ~smp[p];
                TRIG_HIGH: mode_hit = smp[p];
                TRIG_RISE: mode_hit = smp[p] & ~prev[p];
                TRIG_FALL: mode_hit = ~smp[p] & prev[p];
            endcase
        end

        // output pins never raise a flag (R9)
        assign set_vec[p] = ~dir[p] & (both[p] ? any_edge : mode_hit);
    end
endmodule

// File: rtl/gpio_irq_merge.sv
module gpio_irq_merge
    import gpio_irq_pkg::*;
#(
    parameter int N     = NPINS,
    parameter bit SPLIT = 1'b0
) (
    input  logic [N-1:0] flags,
    input  logic [N-1:0] mask,
    output logic [1:0]   irq
);
    localparam int H = N / 2;

    logic [N-1:0] live;
    assign live = flags & mask;

    if (SPLIT) begin : g_split
        assign irq[0] = |live[H-1:0];
        assign irq[1] = |live[N-1:H];
    end else begin : g_single
        assign irq[0] = |live;
        assign irq[1] = 1'b0;
    end
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
    import gpio_irq_pkg::*;
#(
    parameter bit SPLIT_IRQ     = 1'b0,
    parameter bit HAS_BOTH_EDGE = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe,
    output logic [1:0]        irq
);
    logic [NPINS-1:0] dr_q;
    logic [NPINS-1:0] dir_q;
    logic [CFG_W-1:0] cfg_q;
    logic [NPINS-1:0] mask_q;
    logic [NPINS-1:0] flag_q;
    logic [NPINS-1:0] esel_q;
    logic [NPINS-1:0] prev_q;
    logic [NPINS-1:0] smp;
    logic [NPINS-1:0] set_vec;
    logic [NPINS-1:0] clr_vec;
    logic [NREGS-1:0] wr_en;
    logic             word_ok;
    reg_sel_e         sel;
    logic [31:0]      rd_val;

    // address decode: word-aligned offsets inside the 32-byte window only (R12)
    assign word_ok = (bus_addr[1:0] == 2'b00) && ((bus_addr >> 5) == '0);
    assign sel     = reg_sel_e'(bus_addr[4:2]);

    always_comb begin
        wr_en = '0;
        if (bus_wr && word_ok) begin
            wr_en[sel] = 1'b1;
        end
    end

    assign clr_vec = wr_en[REG_FLAG] ? bus_wdata : '0;

    gpio_sync2 #(.W(NPINS)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (pin_in),
        .q_sync  (smp)
    );

    gpio_trig_detect #(.N(NPINS)) u_detect (
        .smp     (smp),
        .prev    (prev_q),
        .dir     (dir_q),
        .cfg     (cfg_q),
        .both    (esel_q),
        .set_vec (set_vec)
    );

    gpio_irq_merge #(.N(NPINS), .SPLIT(SPLIT_IRQ)) u_merge (
        .flags (flag_q),
        .mask  (mask_q),
        .irq   (irq)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dr_q   <= '0;
            dir_q  <= '0;
            cfg_q  <= '0;
            mask_q <= '0;
            flag_q <= '0;
            prev_q <= '0;
        end else begin
            if (wr_en[REG_DATA])   dr_q             <= bus_wdata;
            if (wr_en[REG_DIR])    dir_q            <= bus_wdata;
            if (wr_en[REG_CFG_LO]) cfg_q[31:0]      <= bus_wdata;
            if (wr_en[REG_CFG_HI]) cfg_q[63:32]     <= bus_wdata;
            if (wr_en[REG_MASK])   mask_q           <= bus_wdata;
            // a new detection wins over a clear in the same cycle (R8)
            flag_q <= (flag_q & ~clr_vec) | set_vec;
            prev_q <= smp;
        end
    end

    if (HAS_BOTH_EDGE) begin : g_both
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                esel_q <= '0;
            end else if (wr_en[REG_BOTH]) begin
                esel_q <= bus_wdata;
            end
        end
    end else begin : g_no_both
        assign esel_q = '0;
    end

    always_comb begin
        rd_val = '0;
        if (word_ok) begin
            unique case (sel)
                REG_DATA:   rd_val = (dr_q & dir_q) | (smp & ~dir_q);
                REG_DIR:    rd_val = dir_q;
                REG_STAT:   rd_val = smp & ~dir_q;
                REG_CFG_LO: rd_val = cfg_q[31:0];
                REG_CFG_HI: rd_val = cfg_q[63:32];
                REG_MASK:   rd_val = mask_q;
                REG_FLAG:   rd_val = flag_q;
                REG_BOTH:   rd_val = esel_q;
            endcase
        end
    end

    assign bus_rdata = rd_val;
    assign pin_oe    = dir_q;
    assign pin_out   = dr_q & dir_q;
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk
    import gpio_irq_pkg::*;
#(
    parameter bit SPLIT_IRQ = 1'b0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic [NPINS-1:0]  pin_oe,
    input logic [1:0]        irq,
    input logic [NPINS-1:0]  dir_q,
    input logic [NPINS-1:0]  mask_q,
    input logic [NPINS-1:0]  flag_q,
    input logic [NPINS-1:0]  set_vec
);
    assert_dir_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 6'h04) |=> (pin_oe == $past(bus_wdata)));

    assert_stat_hides_outputs_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 6'h08) |-> ((bus_rdata & pin_oe) == '0));

    assert_flag_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 6'h18) |=>
            ((flag_q & $past(bus_wdata) & ~$past(set_vec)) == '0));

    assert_output_pin_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flag_q & ~$past(flag_q) & $past(dir_q)) == '0));

    assert_mask_gates_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> (irq == 2'b00));

    assert_upper_line_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!SPLIT_IRQ) |-> (irq[1] == 1'b0));

    assert_misaligned_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr[1:0] != 2'b00) |-> (bus_rdata == '0));
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.SPLIT_IRQ(SPLIT_IRQ)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_oe    (pin_oe),
    .irq       (irq),
    .dir_q     (dir_q),
    .mask_q    (mask_q),
    .flag_q    (flag_q),
    .set_vec   (set_vec)
);

// File: tb/gpio_irq_ctrl_test.sv
`timescale 1ns/1ps
module gpio_irq_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] pin_in = '0;
    logic [31:0] rdata, rdata_alt;
    logic [31:0] pin_out, pin_out_alt;
    logic [31:0] pin_oe, pin_oe_alt;
    logic [1:0]  irq, irq_alt;
    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    localparam logic [5:0] A_DATA = 6'h00, A_DIR = 6'h04, A_STAT = 6'h08,
        A_CLO = 6'h0C, A_CHI = 6'h10, A_MASK = 6'h14, A_FLAG = 6'h18, A_BOTH = 6'h1C;
    localparam logic [31:0] ALL_RISE = 32'hAAAA_AAAA;

    always #2.5 clk = ~clk;

    gpio_irq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq));

    gpio_irq_ctrl #(.SPLIT_IRQ(1'b1), .HAS_BOTH_EDGE(1'b0)) uut_alt (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(rdata_alt), .pin_in(pin_in),
        .pin_out(pin_out_alt), .pin_oe(pin_oe_alt), .irq(irq_alt));

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] v, output logic [31:0] va);
        bus_addr = a;
        #0.5;
        v = rdata;
        va = rdata_alt;
    endtask

    task automatic set_pins(input logic [31:0] p);
        @(negedge clk);
        pin_in = p;
    endtask

    task automatic quiet_flags();
        wr(A_CLO, ALL_RISE);
        wr(A_CHI, ALL_RISE);
        wr(A_BOTH, 32'h0);
        tick(1);
        wr(A_FLAG, 32'hFFFF_FFFF);
    endtask

    task automatic t_reset();
        logic [31:0] v, va;
        for (int i = 0; i < 8; i++) begin
            rd(6'(i * 4), v, va);
            check($sformatf("R1 reset read offset %0d", i * 4), v, 32'h0);
        end
        check("R1 reset pin_oe", pin_oe, 32'h0);
        check("R1 reset pin_out", pin_out, 32'h0);
        check("R1 reset irq", {30'h0, irq}, 32'h0);
    endtask

    task automatic t_regs();
        logic [31:0] v, va;
        wr(A_DIR, 32'hA5A5_0F0F);  rd(A_DIR, v, va);  check("R13 dir readback", v, 32'hA5A5_0F0F);
        check("R2 pin_oe follows dir", pin_oe, 32'hA5A5_0F0F);
        wr(A_CLO, 32'h1234_ABCD);  rd(A_CLO, v, va);  check("R13 cfg low readback", v, 32'h1234_ABCD);
        wr(A_CHI, 32'hFEDC_5678);  rd(A_CHI, v, va);  check("R13 cfg high readback", v, 32'hFEDC_5678);
        wr(A_MASK, 32'h0000_FFFF); rd(A_MASK, v, va); check("R13 mask readback", v, 32'h0000_FFFF);
        wr(A_BOTH, 32'h00F0_000F); rd(A_BOTH, v, va);
        check("R13 both-edge readback", v, 32'h00F0_000F);
        check("R11 both-edge absent reads 0", va, 32'h0);
        wr(A_MASK, 32'h0);
        wr(A_DIR, 32'h0);
    endtask

    task automatic t_output();
        logic [31:0] v, va;
        wr(A_DATA, 32'hFFFF_0000);
        wr(A_DIR, 32'h00FF_00FF);
        set_pins(32'h1234_5678);
        tick(3);
        check("R2 pin_out", pin_out, 32'h00FF_0000);
        rd(A_DATA, v, va); check("R3 data read mux", v, 32'h12FF_5600);
        rd(A_STAT, v, va); check("R4 status read", v, 32'h1200_5600);
        set_pins(32'h8765_4321);
        tick(1);
        rd(A_STAT, v, va); check("R4 status after one edge", v, 32'h1200_5600);
        tick(1);
        rd(A_STAT, v, va); check("R4 status after two edges", v, 32'h8700_4300);
        set_pins(32'h0);
        wr(A_DIR, 32'h0);
        check("R2 pin_out with all inputs", pin_out, 32'h0);
        tick(3);
        quiet_flags();
        rd(A_FLAG, v, va); check("R9 config writes give no flag", v, 32'h0);
    endtask

    task automatic t_level();
        logic [31:0] v, va;
        wr(A_CLO, 32'hAAAA_AA6A);   // pin 3 high level
        wr(A_CHI, 32'hAAAA_A8AA);   // pin 20 low level
        tick(1);
        wr(A_FLAG, 32'hFFFF_FFFF);
        rd(A_FLAG, v, va); check("R5 low level flag", v, 32'h0010_0000);
        set_pins(32'h0000_0008);
        tick(3);
        rd(A_FLAG, v, va); check("R5 high level flag", v, 32'h0010_0008);
        wr(A_FLAG, 32'h0010_0000);
        rd(A_FLAG, v, va); check("R8 held level re-sets", v, 32'h0010_0008);
        set_pins(32'h0);
        tick(3);
        wr(A_FLAG, 32'h0000_0008);
        rd(A_FLAG, v, va); check("R8 write-one clears, zero keeps", v, 32'h0010_0000);
        quiet_flags();
    endtask

    task automatic t_edge();
        logic [31:0] v, va;
        wr(A_CLO, 32'hAAAE_AAAA);   // pin 9 falling, pin 8 rising
        tick(1);
        wr(A_FLAG, 32'hFFFF_FFFF);
        set_pins(32'h0000_0300);
        tick(2);
        rd(A_FLAG, v, va); check("R6 no flag after two edges", v, 32'h0);
        tick(1);
        rd(A_FLAG, v, va); check("R6 rising flag", v, 32'h0000_0100);
        wr(A_FLAG, 32'hFFFF_FFFF);
        set_pins(32'h0);
        tick(3);
        rd(A_FLAG, v, va); check("R6 falling flag", v, 32'h0000_0200);
        quiet_flags();
    endtask

    task automatic t_both();
        logic [31:0] v, va;
        wr(A_BOTH, 32'h0000_1000);
        wr(A_CLO, 32'hA8AA_AAAA);   // pin 12 low level, overridden
        tick(1);
        wr(A_FLAG, 32'hFFFF_FFFF);
        rd(A_FLAG, v, va);
        check("R7 override ignores level mode", v, 32'h0);
        check("R11 absent override keeps level mode", va, 32'h0000_1000);
        set_pins(32'h0000_1000);
        tick(3);
        rd(A_FLAG, v, va); check("R7 rise sets flag", v, 32'h0000_1000);
        wr(A_FLAG, 32'hFFFF_FFFF);
        set_pins(32'h0);
        tick(3);
        rd(A_FLAG, v, va); check("R7 fall sets flag", v, 32'h0000_1000);
        quiet_flags();
    endtask

    task automatic t_outpin();
        logic [31:0] v, va;
        wr(A_DIR, 32'h0000_0010);
        set_pins(32'h0000_0010);
        tick(4);
        rd(A_FLAG, v, va); check("R9 output pin raises no flag", v, 32'h0);
        wr(A_DIR, 32'h0);
        tick(2);
        rd(A_FLAG, v, va); check("R9 direction change no edge", v, 32'h0);
        wr(A_CLO, 32'hAAAA_ABAA);   // pin 4 falling
        tick(2);
        rd(A_FLAG, v, va); check("R9 mode change no edge", v, 32'h0);
        set_pins(32'h0);
        tick(3);
        rd(A_FLAG, v, va); check("R9 real edge still flags", v, 32'h0000_0010);
        quiet_flags();
    endtask

    task automatic t_irq();
        logic [31:0] v, va;
        wr(A_MASK, 32'h0);
        set_pins(32'h4000_0004);
        tick(3);
        rd(A_FLAG, v, va); check("R10 flags present", v, 32'h4000_0004);
        check("R10 masked irq", {30'h0, irq}, 32'h0);
        check("R10 masked irq split", {30'h0, irq_alt}, 32'h0);
        wr(A_MASK, 32'h0000_0004);
        check("R10 low pin irq", {30'h0, irq}, 32'h1);
        check("R10 low pin irq split", {30'h0, irq_alt}, 32'h1);
        wr(A_MASK, 32'h4000_0000);
        check("R10 high pin irq combined", {30'h0, irq}, 32'h1);
        check("R10 high pin irq split", {30'h0, irq_alt}, 32'h2);
        wr(A_MASK, 32'h0);
        set_pins(32'h0);
        tick(3);
        wr(A_FLAG, 32'hFFFF_FFFF);
    endtask

    task automatic t_undef();
        logic [31:0] v, va;
        wr(A_DIR, 32'h0000_F00F);
        wr(6'h20, 32'hFFFF_FFFF);
        rd(6'h20, v, va); check("R12 undefined offset reads 0", v, 32'h0);
        wr(6'h05, 32'hFFFF_FFFF);
        rd(6'h05, v, va); check("R12 misaligned reads 0", v, 32'h0);
        wr(6'h3C, 32'hFFFF_FFFF);
        rd(A_DIR, v, va); check("R12 dir untouched", v, 32'h0000_F00F);
        rd(A_MASK, v, va); check("R12 mask untouched", v, 32'h0);
        wr(A_BOTH, 32'hFFFF_FFFF);
        rd(A_BOTH, v, va); check("R11 absent register ignores write", va, 32'h0);
        wr(A_BOTH, 32'h0);
        wr(A_DIR, 32'h0);
    endtask

    initial begin
        tick(3);
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        tick(2);
        t_regs();
        t_output();
        t_level();
        t_edge();
        t_both();
        t_outpin();
        t_irq();
        t_undef();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog R1 actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule